// File: doc/BRIEF.md
# Shared Cell Buffer with Per-Output Linked Queues

This block is the central cell store of a small switch. Cells that arrive from any input are written into one pooled RAM. Each cell carries the number of the output it is bound for. Storage is not split up ahead of time between outputs. Any free slot can hold a cell for any output, so one busy output can use the whole pool while the other outputs are idle.

The control logic keeps one logical FIFO per output. Each FIFO is a linked list of slot indices: a head pointer, a tail pointer, a length, and a shared next-slot array. A separate circular list of free slot indices hands out one slot for each accepted enqueue. It takes the slot back when that cell is dequeued.

In each cycle the block takes at most one enqueue and at most one dequeue, and the two may be in the same cycle. Each cell is written to the RAM once when it arrives and read from it once when it leaves. The current length of every output queue is visible at the ports, together with the total number of occupied slots, a full flag and a count of rejected cells.

Top module: `shared_cell_buffer`

## Requirements
- R1: After reset, every queue length, `used_slots`, `drop_count` and `deq_out_valid` are 0, and `full` is 0.
- R2: When `enq_valid` is high and `full` is low at a rising edge, the cell is accepted. After that edge, the length of queue `enq_dest` is one higher. Queue i's length sits in `qlen[i*CNT_W +: CNT_W]`, where CNT_W = $clog2(NUM_SLOTS+1).
- R3: Cells leave each output queue in the order they were accepted for that output. For a dequeue served at edge t, `deq_out_valid` is high and `deq_out_data` holds the cell in the cycle after edge t, and only then.
- R4: A single output queue can hold all NUM_SLOTS cells at once.
- R5: `full` is high exactly when `used_slots` equals NUM_SLOTS. An enqueue is judged against `full` as it stands at the start of its cycle. If `full` is high, the cell is rejected: no queue changes and `drop_count` rises by one, wrapping modulo 2^DROP_W. This holds even when a dequeue in the same cycle frees a slot.
- R6: A dequeue request for an empty queue gives `deq_out_valid` low in the next cycle and changes no length.
- R7: The sum of all queue lengths always equals `used_slots`.
- R8: An enqueue and a dequeue in the same cycle are both served. This includes the case where both target the same output and that queue holds exactly one cell: the old cell is returned and the new one becomes the only entry.
- R9: A slot freed by a dequeue can take a new cell: after a dequeue from a full buffer, the next enqueue is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid | input | 1 | Cell offered for enqueue this cycle |
| enq_dest | input | $clog2(NUM_OUT) | Destination output of the offered cell |
| enq_data | input | DATA_W | Cell payload |
| deq_req | input | 1 | Dequeue request this cycle |
| deq_port | input | $clog2(NUM_OUT) | Output whose queue is dequeued |
| deq_out_valid | output | 1 | Returned cell valid (one cycle after request) |
| deq_out_data | output | DATA_W | Returned cell payload |
| qlen | output | NUM_OUT*CNT_W | Per-output queue lengths, queue i at bits i*CNT_W upward |
| used_slots | output | CNT_W | Number of occupied slots |
| full | output | 1 | No free slot remains |
| drop_count | output | DROP_W | Count of rejected enqueues, wrapping |

## Verification
The enqueue and dequeue paths can both fire in the same cycle. The risky cases are a single-cell queue that is drained and refilled at the same edge, and an enqueue offered to a full buffer while a dequeue frees a slot. The bench provokes both cases on purpose. It also runs a long mixed stretch of random traffic in which overlapping operations are common. A behavioural model built from per-output queues applies the dequeue against the state at the start of the cycle and then the enqueue. Lengths, occupancy, the full flag, the drop count and the returned cell are compared with the model after every clock.

// File: rtl/scb_pkg.sv
package scb_pkg;
    localparam int SCB_DEF_OUTS   = 4;
    localparam int SCB_DEF_SLOTS  = 32;
    localparam int SCB_DEF_DATA_W = 16;
    localparam int SCB_DEF_DROP_W = 16;

    // width of an index into n items, never less than one bit
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // width of a count from 0 to n inclusive
    function automatic int cnt_w(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/scb_free_list.sv
module scb_free_list
    import scb_pkg::*;
#(
    parameter int NUM_SLOTS = SCB_DEF_SLOTS,
    localparam int SW = idx_w(NUM_SLOTS),
    localparam int CW = cnt_w(NUM_SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_i,
    input  logic          push_i,
    input  logic [SW-1:0] push_slot_i,
    output logic [SW-1:0] pop_slot_o,
    output logic          empty_o,
    output logic [CW-1:0] free_cnt_o
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0][SW-1:0] ring;
        logic [SW-1:0]                rd;
        logic [SW-1:0]                wr;
        logic [CW-1:0]                cnt;
    } fl_state_t;

    fl_state_t st_d, st_q;

    function automatic logic [SW-1:0] wrap_inc(input logic [SW-1:0] p);
        return (p == SW'(NUM_SLOTS - 1)) ? '0 : p + SW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (pop_i) begin
            st_d.rd = wrap_inc(st_q.rd);
        end
        if (push_i) begin
            st_d.ring[st_q.wr] = push_slot_i;
            st_d.wr            = wrap_inc(st_q.wr);
        end
        if (pop_i && !push_i) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end else if (push_i && !pop_i) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                st_q.ring[i] <= SW'(i);
            end
            st_q.rd  <= '0;
            st_q.wr  <= '0;
            st_q.cnt <= CW'(NUM_SLOTS);
        end else begin
            st_q <= st_d;
        end
    end

    assign pop_slot_o = st_q.ring[st_q.rd];
    assign empty_o    = (st_q.cnt == '0);
    assign free_cnt_o = st_q.cnt;

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |-> (st_q.cnt < CW'(NUM_SLOTS)));

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (st_q.cnt != '0));
endmodule

// File: rtl/scb_queue_ctrl.sv
module scb_queue_ctrl
    import scb_pkg::*;
#(
    parameter int NUM_OUT   = SCB_DEF_OUTS,
    parameter int NUM_SLOTS = SCB_DEF_SLOTS,
    localparam int SW = idx_w(NUM_SLOTS),
    localparam int OW = idx_w(NUM_OUT),
    localparam int CW = cnt_w(NUM_SLOTS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enq_i,
    input  logic [OW-1:0]              enq_q_i,
    input  logic [SW-1:0]              enq_slot_i,
    input  logic                       deq_i,
    input  logic [OW-1:0]              deq_q_i,
    output logic [SW-1:0]              head_slot_o,
    output logic [NUM_OUT-1:0][CW-1:0] len_o
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0][SW-1:0] nxt;
        logic [NUM_OUT-1:0][SW-1:0]   head;
        logic [NUM_OUT-1:0][SW-1:0]   tail;
        logic [NUM_OUT-1:0][CW-1:0]   len;
    } qc_state_t;

    qc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // link the new slot behind the current tail of a non-empty queue
        if (enq_i && st_q.len[enq_q_i] != '0) begin
            st_d.nxt[st_q.tail[enq_q_i]] = enq_slot_i;
        end
        if (deq_i) begin
            st_d.head[deq_q_i] = st_q.nxt[st_q.head[deq_q_i]];
            st_d.len[deq_q_i]  = st_q.len[deq_q_i] - CW'(1);
        end
        // applied after the dequeue so a drained queue restarts cleanly
        if (enq_i) begin
            if (st_d.len[enq_q_i] == '0) begin
                st_d.head[enq_q_i] = enq_slot_i;
            end
            st_d.tail[enq_q_i] = enq_slot_i;
            st_d.len[enq_q_i]  = st_d.len[enq_q_i] + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_slot_o = st_q.head[deq_q_i];
    assign len_o       = st_q.len;

    // R2
    enq_len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_i && !deq_i) |=> (st_q.len[$past(enq_q_i)] == $past(st_q.len[enq_q_i]) + CW'(1)));

    // R6
    deq_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deq_i |-> (st_q.len[deq_q_i] != '0));
endmodule

// File: rtl/scb_cell_ram.sv
module scb_cell_ram
    import scb_pkg::*;
#(
    parameter int NUM_SLOTS = SCB_DEF_SLOTS,
    parameter int DATA_W    = SCB_DEF_DATA_W,
    localparam int SW = idx_w(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [SW-1:0]     wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [SW-1:0]     rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] cells_q [NUM_SLOTS];
    logic [DATA_W-1:0] rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            cells_q[wr_addr_i] <= wr_data_i;
        end
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en_i) begin
            rd_d = cells_q[rd_addr_i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data_o = rd_q;

    // R8: a slot being read out is never the slot being filled
    no_rw_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && rd_en_i) |-> (wr_addr_i != rd_addr_i));
endmodule

// File: rtl/shared_cell_buffer.sv
module shared_cell_buffer
    import scb_pkg::*;
#(
    parameter int NUM_OUT   = SCB_DEF_OUTS,
    parameter int NUM_SLOTS = SCB_DEF_SLOTS,
    parameter int DATA_W    = SCB_DEF_DATA_W,
    parameter int DROP_W    = SCB_DEF_DROP_W,
    localparam int SW = idx_w(NUM_SLOTS),
    localparam int OW = idx_w(NUM_OUT),
    localparam int CW = cnt_w(NUM_SLOTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enq_valid,
    input  logic [OW-1:0]         enq_dest,
    input  logic [DATA_W-1:0]     enq_data,
    input  logic                  deq_req,
    input  logic [OW-1:0]         deq_port,
    output logic                  deq_out_valid,
    output logic [DATA_W-1:0]     deq_out_data,
    output logic [NUM_OUT*CW-1:0] qlen,
    output logic [CW-1:0]         used_slots,
    output logic                  full,
    output logic [DROP_W-1:0]     drop_count
);
    typedef struct packed {
        logic              out_vld;
        logic [DROP_W-1:0] drops;
    } top_state_t;

    top_state_t st_d, st_q;

    logic                       fl_empty;
    logic [SW-1:0]              fl_slot;
    logic [CW-1:0]              fl_free;
    logic [SW-1:0]              head_slot;
    logic [NUM_OUT-1:0][CW-1:0] lens;
    logic                       enq_ok;
    logic                       deq_ok;

    assign enq_ok = enq_valid && !fl_empty;
    assign deq_ok = deq_req && (lens[deq_port] != '0);

    scb_free_list #(.NUM_SLOTS(NUM_SLOTS)) u_free (
        .clk         (clk),
        .rst_n       (rst_n),
        .pop_i       (enq_ok),
        .push_i      (deq_ok),
        .push_slot_i (head_slot),
        .pop_slot_o  (fl_slot),
        .empty_o     (fl_empty),
        .free_cnt_o  (fl_free)
    );

    scb_queue_ctrl #(.NUM_OUT(NUM_OUT), .NUM_SLOTS(NUM_SLOTS)) u_qctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enq_i       (enq_ok),
        .enq_q_i     (enq_dest),
        .enq_slot_i  (fl_slot),
        .deq_i       (deq_ok),
        .deq_q_i     (deq_port),
        .head_slot_o (head_slot),
        .len_o       (lens)
    );

    scb_cell_ram #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (enq_ok),
        .wr_addr_i (fl_slot),
        .wr_data_i (enq_data),
        .rd_en_i   (deq_ok),
        .rd_addr_i (head_slot),
        .rd_data_o (deq_out_data)
    );

    always_comb begin
        st_d         = st_q;
        st_d.out_vld = deq_ok;
        if (enq_valid && fl_empty) begin
            st_d.drops = st_q.drops + DROP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar g = 0; g < NUM_OUT; g++) begin : g_qlen
            assign qlen[g*CW +: CW] = lens[g];
        end
    endgenerate

    assign used_slots    = CW'(NUM_SLOTS) - fl_free;
    assign full          = fl_empty;
    assign drop_count    = st_q.drops;
    assign deq_out_valid = st_q.out_vld;

    // sum of the queue-controller lengths, for the occupancy check
    logic [CW-1:0] len_sum;
    always_comb begin
        len_sum = '0;
        for (int i = 0; i < NUM_OUT; i++) begin
            len_sum = len_sum + lens[i];
        end
    end

    // R7
    len_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_sum == used_slots);

    // R5
    drop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && full) |=> (drop_count == $past(drop_count) + DROP_W'(1)));

    // R6
    empty_deq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_req && lens[deq_port] == '0) |=> !deq_out_valid);

    // R3
    out_valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(deq_out_valid) |-> $past(deq_req));
endmodule

// File: tb/shared_cell_buffer_test.sv
`timescale 1ns/1ps
module shared_cell_buffer_test;
    localparam int NO = 4;
    localparam int NS = 32;
    localparam int DW = 16;
    localparam int CW = $clog2(NS + 1);
    localparam int OW = $clog2(NO);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enq_valid = 1'b0;
    logic [OW-1:0] enq_dest = '0;
    logic [DW-1:0] enq_data = '0;
    logic          deq_req = 1'b0;
    logic [OW-1:0] deq_port = '0;
    logic          deq_out_valid;
    logic [DW-1:0] deq_out_data;
    logic [NO*CW-1:0] qlen;
    logic [CW-1:0] used_slots;
    logic          full;
    logic [15:0]   drop_count;

    int checks = 0;
    int errors = 0;

    // behavioural model
    int mq [NO][$];
    int m_drops = 0;
    int m_vld = 0;
    int m_data = 0;
    int seqno = 1;

    always #2.5 clk = ~clk;

    shared_cell_buffer uut (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_dest(enq_dest), .enq_data(enq_data),
        .deq_req(deq_req), .deq_port(deq_port),
        .deq_out_valid(deq_out_valid), .deq_out_data(deq_out_data),
        .qlen(qlen), .used_slots(used_slots), .full(full),
        .drop_count(drop_count)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int m_used();
        int s = 0;
        for (int i = 0; i < NO; i++) s += mq[i].size();
        return s;
    endfunction

    task automatic compare(input string ph);
        for (int i = 0; i < NO; i++)
            chk({ph, " R2 qlen"}, int'(qlen[i*CW +: CW]), mq[i].size());
        chk({ph, " R7 used_slots"}, int'(used_slots), m_used());
        chk({ph, " R5 full"}, int'(full), int'(m_used() == NS));
        chk({ph, " R5 drop_count"}, int'(drop_count), m_drops % 65536);
        chk({ph, " R6 deq_out_valid"}, int'(deq_out_valid), m_vld);
        if (m_vld != 0) chk({ph, " R3 deq_out_data"}, int'(deq_out_data), m_data);
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input string ph, input bit ev, input int ed,
                       input bit dr, input int dp);
        int dat;
        bit was_full;
        dat = seqno & 16'hffff;
        seqno++;
        enq_valid = ev; enq_dest = OW'(ed); enq_data = DW'(dat);
        deq_req = dr;  deq_port = OW'(dp);
        @(posedge clk);
        was_full = (m_used() == NS);
        m_vld = 0;
        if (dr && mq[dp].size() > 0) begin
            m_data = mq[dp].pop_front();
            m_vld = 1;
        end
        if (ev) begin
            if (was_full) m_drops++;
            else mq[ed].push_back(dat);
        end
        @(negedge clk);
        compare(ph);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        // basic enqueue to several outputs, then ordered dequeue
        for (int i = 0; i < 8; i++) cyc("R2 fill", 1, i % NO, 0, 0);
        for (int i = 0; i < 8; i++) cyc("R3 drain", 0, 0, 1, i % NO);
        // empty queue dequeues
        for (int i = 0; i < NO; i++) cyc("R6 empty deq", 0, 0, 1, i);
        // same output single-cell refill at the dequeue edge
        cyc("R8 prime", 1, 1, 0, 0);
        for (int i = 0; i < 4; i++) cyc("R8 one-cell swap", 1, 1, 1, 1);
        cyc("R8 drain", 0, 0, 1, 1);
        // empty queue, enqueue and dequeue same output
        cyc("R8 empty both", 1, 3, 1, 3);
        cyc("R8 drain2", 0, 0, 1, 3);
        // one output takes every slot
        for (int i = 0; i < NS; i++) cyc("R4 hog", 1, 2, 0, 0);
        for (int i = 0; i < 3; i++) cyc("R5 reject", 1, i, 0, 0);
        cyc("R5 full with deq", 1, 0, 1, 2);
        cyc("R9 reuse", 1, 0, 0, 0);
        cyc("R5 full again", 1, 1, 0, 0);
        for (int i = 0; i < NS; i++) cyc("R3 drain all", 0, 0, 1, (i < NS - 1) ? 2 : 0);
        // mixed traffic
        for (int i = 0; i < 4000; i++) begin
            bit ev = ($urandom_range(0, 99) < 55);
            bit dr = ($urandom_range(0, 99) < 45);
            cyc("R8 mixed", ev, $urandom_range(0, NO - 1), dr, $urandom_range(0, NO - 1));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule